// File: doc/BRIEF.md
# Byte-wide GPIO port with pull and pin-function control

This block is one 8-bit general-purpose I/O port seen by the processor as a handful of byte registers on a simple register bus. Software programs per-pin direction, drive level, pull resistor enable and a two-bit pin-function code. The block turns those settings into per-pin pad controls: output enable, output level, pull enable and pull polarity. It also hands the function code to the pad multiplexer.

The port's external levels pass through a two-stage synchronizer before software can read them. The drive-level register has a second job. On a pin that drives, it holds the driven level. On a pin that is an input with its resistor enabled, it chooses whether the pull goes up or down. A pin belongs to the GPIO logic only while both of its function-select bits are clear. Otherwise every GPIO pad control for that pin is held low, and the function code decides what drives the pad.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, so pin_oe, pin_out, pull_en, pull_up and pin_alt are all 0 and every pin is an input with no pull.
- R2: Register map, byte addresses: input level 0x20 (read only), drive level 0x21, direction 0x22, function select low 0x26, resistor enable 0x27, function select high 0x41. A write with bus_we high lands at the rising clock edge. A read returns the addressed register combinationally on bus_rdata, and reading a writable register returns the last value written.
- R3: A GPIO-owned pin whose direction bit is 1 has pin_oe high. A direction bit of 0 makes the pin an input with pin_oe low.
- R4: pin_out for a GPIO-owned output pin equals its drive-level bit. pin_out is 0 on input pins.
- R5: On a GPIO-owned input pin whose resistor-enable bit is 1, pull_en is 1 and pull_up equals the drive-level bit (1 means pull-up, 0 means pull-down).
- R6: The resistor-enable bit is ignored on output pins: pull_en and pull_up stay 0 there.
- R7: A pin is GPIO-owned only when both of its select bits are 0. For any other pin, pin_oe, pin_out, pull_en and pull_up are 0. pin_alt bits [2i+1:2i] always carry {select high bit i, select low bit i}.
- R8: Reading 0x20 returns pin_in as it was two rising edges earlier, through two synchronizer flops. A write to 0x20 changes no register.
- R9: Reads of any address outside the map return 0, and writes to such addresses change no register.
- R10: Bus cycles with bus_we low change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Raw pad input levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven level |
| pull_en | output | 8 | Per-pin pull resistor enable |
| pull_up | output | 8 | Per-pin pull polarity, 1 = up |
| pin_alt | output | 16 | Per-pin function code {sel_hi, sel_lo}, pin i at [2i+1:2i] |

## Verification
The assertions assume that pin_in, bus_addr, bus_we and bus_wdata settle away from the rising edge. They also assume that a register read refers to the address present in the same cycle. For the synchronizer check, the checker waits two edges after reset before it compares the input-register read with pin_in from two edges earlier, so the reset value of the flops is never compared. The bench changes every input at the falling edge and samples half a cycle later. It therefore never places a pin transition at the sampling edge, where the synchronizer's output cycle would be undefined.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_LEVEL,
    RS_DRIVE,
    RS_DIR,
    RS_FSEL_LO,
    RS_FSEL_HI,
    RS_PULL
  } reg_sel_e;

  // A pin is handed to GPIO only when both function-select bits are clear.
  function automatic logic gpio_owned(input logic sel_lo, input logic sel_hi);
    return !(sel_lo || sel_hi);
  endfunction

  // Pull requested only on an owned input pin with its resistor enabled.
  function automatic logic pull_active(input logic own, input logic dir, input logic ren);
    return own && !dir && ren;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d_async;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int             W          = 8,
  parameter int             AW         = 8,
  parameter logic [AW-1:0]  A_LEVEL    = 8'h20,
  parameter logic [AW-1:0]  A_DRIVE    = 8'h21,
  parameter logic [AW-1:0]  A_DIR      = 8'h22,
  parameter logic [AW-1:0]  A_FSEL_LO  = 8'h26,
  parameter logic [AW-1:0]  A_PULL     = 8'h27,
  parameter logic [AW-1:0]  A_FSEL_HI  = 8'h41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  level_sync,
  output logic [W-1:0]  drive_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  fsel_lo_q,
  output logic [W-1:0]  fsel_hi_q,
  output logic [W-1:0]  pull_q
);
  reg_sel_e sel;

  always_comb begin
    if      (bus_addr == A_LEVEL)   sel = RS_LEVEL;
    else if (bus_addr == A_DRIVE)   sel = RS_DRIVE;
    else if (bus_addr == A_DIR)     sel = RS_DIR;
    else if (bus_addr == A_FSEL_LO) sel = RS_FSEL_LO;
    else if (bus_addr == A_FSEL_HI) sel = RS_FSEL_HI;
    else if (bus_addr == A_PULL)    sel = RS_PULL;
    else                            sel = RS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q   <= '0;
      dir_q     <= '0;
      fsel_lo_q <= '0;
      fsel_hi_q <= '0;
      pull_q    <= '0;
    end else if (bus_we) begin
      case (sel)
        RS_DRIVE:   drive_q   <= bus_wdata;
        RS_DIR:     dir_q     <= bus_wdata;
        RS_FSEL_LO: fsel_lo_q <= bus_wdata;
        RS_FSEL_HI: fsel_hi_q <= bus_wdata;
        RS_PULL:    pull_q    <= bus_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RS_LEVEL:   bus_rdata = level_sync;
      RS_DRIVE:   bus_rdata = drive_q;
      RS_DIR:     bus_rdata = dir_q;
      RS_FSEL_LO: bus_rdata = fsel_lo_q;
      RS_FSEL_HI: bus_rdata = fsel_hi_q;
      RS_PULL:    bus_rdata = pull_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   drive_q,
  input  logic [W-1:0]   dir_q,
  input  logic [W-1:0]   fsel_lo_q,
  input  logic [W-1:0]   fsel_hi_q,
  input  logic [W-1:0]   pull_q,
  output logic [W-1:0]   pin_oe,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pull_en,
  output logic [W-1:0]   pull_up,
  output logic [2*W-1:0] pin_alt
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic own;
      logic pulling;
      assign own            = gpio_owned(fsel_lo_q[i], fsel_hi_q[i]);
      assign pulling        = pull_active(own, dir_q[i], pull_q[i]);
      assign pin_oe[i]      = own && dir_q[i];
      assign pin_out[i]     = own && dir_q[i] && drive_q[i];
      assign pull_en[i]     = pulling;
      assign pull_up[i]     = pulling && drive_q[i];
      assign pin_alt[2*i+1] = fsel_hi_q[i];
      assign pin_alt[2*i]   = fsel_lo_q[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pull_en,
  output logic [W-1:0]  pull_up,
  output logic [2*W-1:0] pin_alt
);
  localparam int SYNC_STAGES = 2;

  logic [W-1:0] level_sync;
  logic [W-1:0] drive_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] fsel_lo_q;
  logic [W-1:0] fsel_hi_q;
  logic [W-1:0] pull_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (level_sync)
  );

  gpio_regfile #(.W(W), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .level_sync (level_sync),
    .drive_q    (drive_q),
    .dir_q      (dir_q),
    .fsel_lo_q  (fsel_lo_q),
    .fsel_hi_q  (fsel_hi_q),
    .pull_q     (pull_q)
  );

  gpio_padctl #(.W(W)) u_pad (
    .drive_q   (drive_q),
    .dir_q     (dir_q),
    .fsel_lo_q (fsel_lo_q),
    .fsel_hi_q (fsel_hi_q),
    .pull_q    (pull_q),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pull_en   (pull_en),
    .pull_up   (pull_up),
    .pin_alt   (pin_alt)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pin_in,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pull_en,
  input logic [W-1:0]  pull_up,
  input logic [2*W-1:0] pin_alt
);
  logic [1:0]   since_rst;
  logic [W-1:0] alt_any;
  logic         addr_mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    for (int i = 0; i < W; i++) alt_any[i] = pin_alt[2*i] | pin_alt[2*i+1];
  end

  assign addr_mapped = (bus_addr == 8'h20) || (bus_addr == 8'h21) || (bus_addr == 8'h22) ||
                       (bus_addr == 8'h26) || (bus_addr == 8'h27) || (bus_addr == 8'h41);

  // R3: a direction write shows on pin_oe for owned pins
  a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h22) |=> ((pin_oe & ~alt_any) == ($past(bus_wdata) & ~alt_any)));

  // R4: the driven level never appears on a pin that is not enabled
  a_r4_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R6: no pull on a driving pin
  a_r6_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pin_oe) == '0);

  // R5: pull-up only where a pull is enabled
  a_r5_up_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & ~pull_en) == '0);

  // R7: pins given to another function carry no GPIO pad control
  a_r7_alt_releases_pad: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out | pull_en | pull_up) & alt_any) == '0);

  // R8: input register is pin_in from two edges back
  a_r8_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && bus_addr == 8'h20) |-> (bus_rdata == $past(pin_in, 2)));

  // R9: unmapped addresses read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (bus_rdata == '0));

  // R10: without a write strobe the pad controls hold
  a_r10_no_we_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && !bus_we) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pull_en) &&
                                        $stable(pull_up) && $stable(pin_alt)));
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pull_en   (pull_en),
  .pull_up   (pull_up),
  .pin_alt   (pin_alt)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {dir, drive, pull, sel_lo, sel_hi, exp_oe, exp_out, exp_pen, exp_pup}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00},
    {8'h0F, 8'hA5, 8'hF0, 8'h00, 8'h00, 8'h0F, 8'h05, 8'hF0, 8'hA0},
    {8'hF0, 8'h3C, 8'hFF, 8'h00, 8'h00, 8'hF0, 8'h30, 8'h0F, 8'h0C},
    {8'hFF, 8'h81, 8'hFF, 8'h01, 8'h80, 8'h7E, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0},
    {8'hAA, 8'h55, 8'h55, 8'h00, 8'h03, 8'hA8, 8'h00, 8'h54, 8'h54}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_oe, pin_out, pull_en, pull_up;
  logic [15:0] pin_alt;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en), .pull_up(pull_up),
    .pin_alt(pin_alt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] interleave(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = lo[i];
      r[2*i+1] = hi[i];
    end
    return r;
  endfunction

  task automatic check_regs(input string req, input logic [7:0] e_drv, input logic [7:0] e_dir,
                            input logic [7:0] e_flo, input logic [7:0] e_pull, input logic [7:0] e_fhi);
    logic [7:0] v;
    rd(8'h21, v); check(req, "drive reg", {8'h00, v}, {8'h00, e_drv});
    rd(8'h22, v); check(req, "dir reg",   {8'h00, v}, {8'h00, e_dir});
    rd(8'h26, v); check(req, "sel lo reg", {8'h00, v}, {8'h00, e_flo});
    rd(8'h27, v); check(req, "pull reg",  {8'h00, v}, {8'h00, e_pull});
    rd(8'h41, v); check(req, "sel hi reg", {8'h00, v}, {8'h00, e_fhi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    // R1 reset state
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pin_oe", {8'h00, pin_oe}, 16'h0);
    check("R1", "pin_out", {8'h00, pin_out}, 16'h0);
    check("R1", "pull_en", {8'h00, pull_en}, 16'h0);
    check("R1", "pull_up", {8'h00, pull_up}, 16'h0);
    check("R1", "pin_alt", pin_alt, 16'h0);
    check_regs("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);

    // Table walk: R2 readback, R3..R7 pad controls
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] d, o, p, sl, sh, eoe, eout, epe, epu;
      {d, o, p, sl, sh, eoe, eout, epe, epu} = VEC[k];
      wr(8'h22, d); wr(8'h21, o); wr(8'h27, p); wr(8'h26, sl); wr(8'h41, sh);
      check_regs("R2", o, d, sl, p, sh);
      check("R3", "pin_oe", {8'h00, pin_oe}, {8'h00, eoe});
      check("R4", "pin_out", {8'h00, pin_out}, {8'h00, eout});
      check("R5", "pull_en", {8'h00, pull_en}, {8'h00, epe});
      check("R6", "pull_up", {8'h00, pull_up}, {8'h00, epu});
      check("R7", "pin_alt", pin_alt, interleave(sl, sh));
    end

    // R8 two-stage input synchronizer
    wr(8'h26, 8'h00); wr(8'h41, 8'h00); wr(8'h22, 8'h00);
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); pin_in = 8'hC3;
    rd(8'h20, v); check("R8", "level after 1 edge", {8'h00, v}, 16'h0000);
    @(negedge clk);
    rd(8'h20, v); check("R8", "level after 2 edges", {8'h00, v}, 16'h005A);
    @(negedge clk);
    rd(8'h20, v); check("R8", "second level", {8'h00, v}, 16'h00C3);
    // R8 write to input register is ignored
    wr(8'h20, 8'h0F);
    rd(8'h20, v); check("R8", "level after write", {8'h00, v}, 16'h00C3);
    check_regs("R8", 8'hFF & 8'h55, 8'h00, 8'h00, 8'h55, 8'h00);

    // R9 unmapped addresses
    rd(8'h00, v); check("R9", "read 0x00", {8'h00, v}, 16'h0);
    rd(8'h23, v); check("R9", "read 0x23", {8'h00, v}, 16'h0);
    rd(8'hFF, v); check("R9", "read 0xFF", {8'h00, v}, 16'h0);
    wr(8'h23, 8'hFF); wr(8'h40, 8'hFF); wr(8'h28, 8'hFF);
    check_regs("R9", 8'h55, 8'h00, 8'h00, 8'h55, 8'h00);

    // R10 no strobe, no write
    @(negedge clk);
    bus_addr = 8'h22; bus_wdata = 8'hFF; bus_we = 1'b0;
    @(negedge clk);
    check("R10", "pin_oe", {8'h00, pin_oe}, 16'h0);
    check_regs("R10", 8'h55, 8'h00, 8'h00, 8'h55, 8'h00);

    // R5/R6 boundary: flipping a pulled pin to output drops its pull
    wr(8'h22, 8'h01);
    check("R6", "pull_en after dir", {8'h00, pull_en}, 16'h0054);
    check("R4", "pin_out bit0", {8'h00, pin_out}, 16'h0001);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pin_oe in reset", {8'h00, pin_oe}, 16'h0);
    check("R1", "pull_en in reset", {8'h00, pull_en}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule